// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master for the clause-22 serial management interface of an Ethernet PHY. A host register block presents four configuration words to it: a mode word (clock divisor and preamble suppression), a command word, an address word (PHY and register number) and a transmit data word. The block drives the management clock and data line and returns a receive data word and a three-bit status word.

The management clock is derived from the system clock by an even divisor and runs only while a frame is in progress. The data line is driven through an output enable. The master changes its output only while the management clock is low. It releases the line for the turnaround and data field of a read, and it samples read data on each rising management clock edge.

A write or read command is carried out once. Software must return the command word to zero before it issues the next one. A scan command polls the addressed register back to back for as long as its bit stays set. After each pass it refreshes the receive data, the invalid flag and the link-fail flag.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word, receive data, `mdc` and `mdio_oe` are all zero.
- R2: One management clock period lasts 2*max(mode_reg[7:1],1) system clocks, with equal high and low phases. mode_reg bit 0 has no effect, and `mdc` stays low whenever busy is clear.
- R3: A frame starts with 32 driven ones unless mode_reg bit 8 is set, in which case it starts directly with the start bits.
- R4: A write frame drives 32 bits MSB first: start 01, opcode 01, PHY address (addr_reg[4:0]), register address (addr_reg[12:8]), turnaround 10, then the 16 bits of txd_reg.
- R5: A read frame drives start 01, opcode 10 and both addresses. From the turnaround onward it releases the line (`mdio_oe`=0). The 16 bits sampled at the rising `mdc` edges of the data field appear MSB first on `rxd_reg` when the frame ends.
- R6: Command bits are cmd_reg[0] scan, [1] read and [2] write, with priority write over read over scan. Busy (status[1]) rises in the clock cycle after the edge at which an idle master sees a command.
- R7: Busy clears at the final falling `mdc` edge of the frame, and the line is released at that edge. A write or read held in cmd_reg is not repeated until cmd_reg has been all zero for at least one cycle.
- R8: Scan repeats frames back to back with busy held high. Invalid (status[2]) is set from scan start until the first pass has finished. When the scan bit clears, the frame in progress completes and the master goes idle.
- R9: At the end of each scan pass, link-fail (status[0]) becomes the inverse of bit 2 of the word that was read.
- R10: `mdio_out` and `mdio_oe` do not change while `mdc` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg | input | 9 | [7:1] half-period divisor, [8] preamble suppression |
| cmd_reg | input | 3 | [0] scan, [1] read, [2] write |
| addr_reg | input | 13 | [4:0] PHY address, [12:8] register address |
| txd_reg | input | 16 | Write data |
| rxd_reg | output | 16 | Last word read |
| status | output | 3 | [0] link-fail, [1] busy, [2] invalid |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Management data from the pad |
| mdio_out | output | 1 | Management data to the pad |
| mdio_oe | output | 1 | Pad output enable |

## Verification
Busy is due one system clock after the command is presented, so the bench drives commands at a falling system clock edge and reads busy at the next one. Serial bits and `mdio_oe` are recorded at each rising `mdc`, which is the moment the PHY side samples them. The MDC period is taken between the last two rising edges of a frame. Receive data, invalid and link-fail change in the same cycle that busy falls or a scan pass closes, so the bench waits for that transition and then compares. Checks that something stays unchanged look at the ports twenty cycles later.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W   = 8;
  localparam int PHY_W   = 5;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 32;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_SCAN  = 2'd2
  } mdio_op_e;

  localparam logic [1:0] SOF      = 2'b01;
  localparam logic [1:0] OPC_WR   = 2'b01;
  localparam logic [1:0] OPC_RD   = 2'b10;
  localparam logic [1:0] TURN_WR  = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int HW = DIV_W - 1;

  logic [HW-1:0] half;
  logic [HW-1:0] cnt_q, cnt_n;
  logic          mdc_q, mdc_n;
  logic          tick;

  // bit 0 of the divisor is dropped so the period is always even
  assign half = (div[DIV_W-1:1] == '0) ? HW'(1) : div[DIV_W-1:1];
  assign tick = run && (cnt_q == half - HW'(1));
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (tick) begin
      cnt_n = '0;
      mdc_n = !mdc_q;
    end else begin
      cnt_n = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               pre_off,
  input  logic               rd_mode,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               active,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_in,
  output logic               bit_o,
  output logic               oe_o,
  output logic [DATA_W-1:0]  rx_o,
  output logic               last_o
);
  localparam int PW  = $clog2(FRAME_W);      // position inside frame word
  localparam int CW  = PW + 1;               // preamble + frame counter
  localparam int TA0 = FRAME_W - DATA_W - 2; // first turnaround position

  logic [CW-1:0]      pos_q, pos_n;
  logic [FRAME_W-1:0] word_q, word_n;
  logic               rdm_q, rdm_n;
  logic [DATA_W-1:0]  rx_q, rx_n;
  logic               in_frame;
  logic [PW-1:0]      fpos;

  assign in_frame = pos_q[CW-1];
  assign fpos     = pos_q[PW-1:0];
  assign last_o   = fall && (pos_q == {CW{1'b1}});
  assign bit_o    = in_frame ? word_q[~fpos] : 1'b1;
  assign oe_o     = active && !(rdm_q && in_frame && (fpos >= PW'(TA0)));
  assign rx_o     = rx_q;

  always_comb begin
    pos_n  = pos_q;
    word_n = word_q;
    rdm_n  = rdm_q;
    rx_n   = rx_q;
    if (load) begin
      pos_n  = pre_off ? {1'b1, {PW{1'b0}}} : '0;
      word_n = word_i;
      rdm_n  = rd_mode;
    end else if (fall && !last_o) begin
      pos_n = pos_q + CW'(1);
    end
    if (rise && in_frame && (fpos >= PW'(FRAME_W - DATA_W)))
      rx_n = {rx_q[DATA_W-2:0], mdio_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      word_q <= '0;
      rdm_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      pos_q  <= pos_n;
      word_q <= word_n;
      rdm_q  <= rdm_n;
      rx_q   <= rx_n;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [8:0]   mode_reg,
  input  logic [2:0]   cmd_reg,
  input  logic [12:0]  addr_reg,
  input  logic [15:0]  txd_reg,
  output logic [15:0]  rxd_reg,
  output logic [2:0]   status,
  output logic         mdc,
  input  logic         mdio_in,
  output logic         mdio_out,
  output logic         mdio_oe
);
  logic              busy_q, busy_n;
  logic              done_q, done_n;
  logic              inv_q, inv_n;
  logic              lf_q, lf_n;
  logic [DATA_W-1:0] rd_q, rd_n;
  mdio_op_e          op_q, op_n;

  logic              rise, fall, frm_last;
  logic [DATA_W-1:0] rx_word;
  logic              want_wr, want_rd, want_sc, start, rescan, load;
  mdio_op_e          start_op, load_op;
  logic [PHY_W-1:0]  phy_a, reg_a;
  logic [FRAME_W-1:0] word;

  assign phy_a   = addr_reg[4:0];
  assign reg_a   = addr_reg[12:8];
  assign want_wr = cmd_reg[2] && !done_q;
  assign want_rd = cmd_reg[1] && !done_q;
  assign want_sc = cmd_reg[0];
  assign start   = !busy_q && (want_wr || want_rd || want_sc);
  assign start_op = want_wr ? OP_WRITE : (want_rd ? OP_READ : OP_SCAN);
  assign rescan  = frm_last && (op_q == OP_SCAN) && cmd_reg[0];
  assign load    = start || rescan;
  assign load_op = start ? start_op : OP_SCAN;
  assign word    = (load_op == OP_WRITE)
                 ? {SOF, OPC_WR, phy_a, reg_a, TURN_WR, txd_reg}
                 : {SOF, OPC_RD, phy_a, reg_a, 2'b11, {DATA_W{1'b1}}};

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .div(mode_reg[7:0]),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .load(load), .pre_off(mode_reg[8]),
    .rd_mode(load_op != OP_WRITE), .word_i(word), .active(busy_q),
    .rise(rise), .fall(fall), .mdio_in(mdio_in), .bit_o(mdio_out),
    .oe_o(mdio_oe), .rx_o(rx_word), .last_o(frm_last)
  );

  always_comb begin
    busy_n = busy_q;
    done_n = done_q;
    inv_n  = inv_q;
    lf_n   = lf_q;
    rd_n   = rd_q;
    op_n   = op_q;
    if (cmd_reg == 3'b000) done_n = 1'b0;
    if (start) begin
      busy_n = 1'b1;
      op_n   = start_op;
      if (start_op == OP_SCAN) inv_n = 1'b1;
    end
    if (frm_last) begin
      case (op_q)
        OP_WRITE: begin
          done_n = 1'b1;
          busy_n = 1'b0;
        end
        OP_READ: begin
          rd_n   = rx_word;
          done_n = 1'b1;
          busy_n = 1'b0;
        end
        default: begin
          rd_n   = rx_word;
          inv_n  = 1'b0;
          lf_n   = !rx_word[2];
          busy_n = cmd_reg[0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      inv_q  <= 1'b0;
      lf_q   <= 1'b0;
      rd_q   <= '0;
      op_q   <= OP_WRITE;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      inv_q  <= inv_n;
      lf_q   <= lf_n;
      rd_q   <= rd_n;
      op_q   <= op_n;
    end
  end

  assign rxd_reg = rd_q;
  assign status  = {inv_q, busy_q, lf_q};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] mode_reg,
  input logic [2:0] status,
  input logic       mdc,
  input logic       mdio_out,
  input logic       mdio_oe
);
  logic [7:0] hi_cnt;
  logic [6:0] half;

  assign half = (mode_reg[7:1] == 7'd0) ? 7'd1 : mode_reg[7:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 8'd0;
    else        hi_cnt <= mdc ? hi_cnt + 8'd1 : 8'd0;
  end

  // R10: data and enable hold while the clock is high
  a_r10_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R2: clock parked low when idle
  a_r2_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> !mdc);

  // R2: high phase equals the half period
  a_r2_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc && $past(mdc)) |-> (hi_cnt == {1'b0, half}));

  // R7: line released when busy drops
  a_r7_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> !mdio_oe);

  // R8: invalid only during an active scan
  a_r8_invalid_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[1]);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .status(status),
  .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  mode_reg = '0;
  logic [2:0]  cmd_reg = '0;
  logic [12:0] addr_reg = '0;
  logic [15:0] txd_reg = '0;
  logic [15:0] rxd_reg;
  logic [2:0]  status;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in;

  always #4 clk = ~clk; // 125 MHz

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .cmd_reg(cmd_reg),
    .addr_reg(addr_reg), .txd_reg(txd_reg), .rxd_reg(rxd_reg),
    .status(status), .mdc(mdc), .mdio_in(mdio_in), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // PHY-side monitor
  logic        mdc_d = 1'b0;
  int          rcount = 0, ocount = 0, t_last = 0, t_prev = 0;
  logic [63:0] log_q = '0;
  logic [15:0] phy_word = '0;
  logic        nopre_b = 1'b0;
  int          rbase = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mdc && !mdc_d) begin
      rcount = rcount + 1;
      t_prev = t_last;
      t_last = cyc;
      if (mdio_oe) begin
        ocount = ocount + 1;
        log_q  = {log_q[62:0], mdio_out};
      end
    end
    mdc_d = mdc;
  end

  always_comb begin
    int flen;
    int p;
    flen = nopre_b ? 32 : 64;
    p = (rcount - rbase) % flen;
    if (p >= flen - 16) mdio_in = phy_word[flen - 1 - p];
    else                mdio_in = 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (status[1] && n < 5000) begin @(negedge clk); n++; end
    chk(tag, {63'd0, status[1]}, 64'd0);
  endtask

  // op(2: 1 write, 2 read) nopre div phy reg data
  localparam logic [36:0] VEC [5] = '{
    {2'd1, 1'b0, 8'd4, 5'h01, 5'h00, 16'hA5C3},
    {2'd2, 1'b0, 8'd6, 5'h1F, 5'h02, 16'h1234},
    {2'd1, 1'b1, 8'd3, 5'h10, 5'h1F, 16'hFFFF},
    {2'd2, 1'b1, 8'd0, 5'h05, 5'h11, 16'h8001},
    {2'd1, 1'b0, 8'd9, 5'h0A, 5'h15, 16'h0F0F}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", {61'd0, status}, 64'd0);
    chk("R1 rxd", {48'd0, rxd_reg}, 64'd0);
    chk("R1 mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);

    for (int i = 0; i < 5; i++) begin
      logic [36:0] v;
      logic        wr, np;
      logic [7:0]  dv;
      logic [4:0]  pa, ra;
      logic [15:0] dat;
      int ob, rb, fb, half;
      v = VEC[i];
      wr = (v[36:35] == 2'd1); np = v[34]; dv = v[33:26];
      pa = v[25:21]; ra = v[20:16]; dat = v[15:0];
      half = (dv[7:1] == 0) ? 1 : int'(dv[7:1]);
      @(negedge clk);
      nopre_b = np; phy_word = dat; rbase = rcount; ob = ocount; rb = rcount;
      mode_reg = {np, dv}; addr_reg = {ra[4:0], 3'b000, pa};
      txd_reg = wr ? dat : 16'h0;
      cmd_reg = wr ? 3'b100 : 3'b010;
      @(negedge clk);
      chk("R6 busy after command", {63'd0, status[1]}, 64'd1);
      wait_idle("R7 busy clears");
      chk("R2 mdc period", 64'(t_last - t_prev), 64'(2 * half));
      chk("R2 mdc idle low", {63'd0, mdc}, 64'd0);
      chk("R3 driven bit count", 64'(ocount - ob), 64'((np ? 0 : 32) + (wr ? 32 : 14)));
      chk("R3 rising edge count", 64'(rcount - rb), 64'(np ? 32 : 64));
      fb = wr ? 32 : 14;
      if (!np) chk("R3 preamble ones", (log_q >> fb) & 64'hFFFF_FFFF, 64'hFFFF_FFFF);
      if (wr)
        chk("R4 write frame", log_q & 64'hFFFF_FFFF,
            {32'd0, 2'b01, 2'b01, pa, ra, 2'b10, dat});
      else begin
        chk("R5 read header", log_q & 64'h3FFF, {50'd0, 2'b01, 2'b10, pa, ra});
        chk("R5 read data", {48'd0, rxd_reg}, {48'd0, dat});
      end
      repeat (20) @(negedge clk);
      chk("R7 held command not repeated", {63'd0, status[1]}, 64'd0);
      cmd_reg = 3'b000;
      @(negedge clk);
    end

    // R6 priority: write and read together performs the write
    @(negedge clk);
    nopre_b = 1'b1; mode_reg = 9'h102; addr_reg = 13'h0203; txd_reg = 16'h5A5A;
    cmd_reg = 3'b111;
    @(negedge clk);
    wait_idle("R6 priority frame end");
    chk("R6 write wins opcode", {62'd0, log_q[29:28]}, 64'd1);
    cmd_reg = 3'b000;
    @(negedge clk);

    // R8/R9 scan
    nopre_b = 1'b1; phy_word = 16'h0000; rbase = rcount;
    mode_reg = 9'h102; addr_reg = 13'h0101;
    cmd_reg = 3'b001;
    @(negedge clk);
    chk("R8 scan busy and invalid", {61'd0, status[2:1]}, 64'd3);
    begin
      int n = 0;
      while (status[2] && n < 5000) begin @(negedge clk); n++; end
    end
    phy_word = 16'h0004;
    chk("R8 invalid cleared after pass", {63'd0, status[2]}, 64'd0);
    chk("R8 busy held during scan", {63'd0, status[1]}, 64'd1);
    chk("R8 scan data", {48'd0, rxd_reg}, 64'd0);
    chk("R9 link-fail set", {63'd0, status[0]}, 64'd1);
    begin
      int n = 0;
      while (rxd_reg != 16'h0004 && n < 5000) begin @(negedge clk); n++; end
    end
    chk("R8 rescan data", {48'd0, rxd_reg}, 64'h4);
    chk("R9 link-fail cleared", {63'd0, status[0]}, 64'd0);
    cmd_reg = 3'b000;
    wait_idle("R8 scan stops");
    chk("R8 idle after scan", {62'd0, mdc, mdio_oe}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule